// File: doc/BRIEF.md
# Slow Clock Source Switch Sequencer

This block decides which oscillator supplies the 32 kHz-class slow clock. After a power-on reset the internal RC oscillator runs and drives the slow clock at once. The crystal oscillator stays powered but disabled.

One software command moves the slow clock to the crystal. The command is a register write whose crystal-select bit is 1. The move happens once and cannot be undone. It runs as a fixed chain of steps:

1. The shared pins are handed to the oscillator.
2. The crystal (or, in bypass mode, the external clock path) is enabled.
3. The block waits a fixed settling period, counted on the RC clock.
4. A glitch-free multiplexer moves the output onto the crystal.
5. The RC oscillator is switched off.

A status output then reports that the crystal is the active source. Only a power-on reset brings the RC source back.

Top module: `slowclk_src_seq`

## Requirements
- R1: While reset is low and after it, until a command is accepted: `rc_osc_en`=1, and `pin_handover`, `xtal_amp_en`, `xtal_bypass`, `clk_sel` and `switch_done` are all 0. In this state `slow_clk` follows `rc_clk`.
- R2: A start command is a cycle with `wr_stb`=1 and `wr_xtal_sel`=1 while the sequencer is idle. At the next `rc_clk` rising edge it raises `pin_handover`. A write with `wr_xtal_sel`=0 has no effect.
- R3: The oscillator enable rises one `rc_clk` edge after `pin_handover`. The enable is `xtal_amp_en`, or `xtal_bypass` in bypass mode. No oscillator enable is ever high while `pin_handover` is low.
- R4: `clk_sel` rises exactly 32,769 `rc_clk` rising edges after the edge that raised the oscillator enable. This span includes a settling wait of exactly 32,768 cycles.
- R5: The output clock never shows a high or low phase shorter than the shorter half period of the two sources. At no time are both source paths open. After completion, `slow_clk` follows `xtal_clk`.
- R6: `switch_done` rises within 16 `rc_clk` cycles of `clk_sel`, once the crystal path is open. `rc_osc_en` falls on the same edge, never earlier.
- R7: Once `switch_done` is 1, it stays 1 and every output holds, whatever is written. Only reset restores the R1 state, and it does so from any step of the sequence.
- R8: `bypass_mode` is captured with the start command. When the captured value is 1, `xtal_bypass` is asserted in place of `xtal_amp_en`. The two are never high together.
- R9: Writes of either select value arriving during the sequence, and changes of `bypass_mode`, leave the sequence and its timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low, sampled on each clock domain |
| rc_clk | input | 1 | Internal RC oscillator clock; clocks the sequencer |
| xtal_clk | input | 1 | Crystal or external bypass clock |
| wr_stb | input | 1 | Control register write strobe, synchronous to rc_clk |
| wr_xtal_sel | input | 1 | Crystal-select bit of the write data |
| bypass_mode | input | 1 | 1 selects external clock bypass instead of the amplifier |
| pin_handover | output | 1 | Requests the shared pins for the oscillator |
| rc_osc_en | output | 1 | RC oscillator enable |
| xtal_amp_en | output | 1 | Crystal amplifier enable |
| xtal_bypass | output | 1 | Crystal bypass enable (external clock path) |
| clk_sel | output | 1 | Source request to the glitch-free multiplexer, 1 = crystal |
| slow_clk | output | 1 | Multiplexed slow clock |
| switch_done | output | 1 | Status: crystal is the active source |

## Verification
The sequencer state decodes straight onto the control outputs. A wrong state therefore shows at the ports on the very next `rc_clk` edge, as a wrong combination of handover, enable, select and status bits. A settling counter that is off by a single count moves the `clk_sel` edge by one cycle, so the bench samples the cycle just before and just after the expected edge. Faults in the multiplexer handshake show up later, within a few source clock periods. They appear as a runt phase on `slow_clk`, or as a `switch_done` that is late or never arrives.

// File: rtl/slowclk_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the slow clock source sequencer.
// Assumes: one state register decodes to all sequencer control outputs.
package slowclk_seq_pkg;

    typedef enum logic [2:0] {
        SQ_RC_RUN    = 3'd0,
        SQ_PIN_GRANT = 3'd1,
        SQ_OSC_START = 3'd2,
        SQ_SETTLE    = 3'd3,
        SQ_HANDOVER  = 3'd4,
        SQ_XTAL_RUN  = 3'd5
    } sq_state_t;

    typedef struct packed {
        logic pin_req;
        logic osc_on;
        logic sel_xtal;
        logic rc_on;
        logic done;
    } sq_ctrl_t;

    // Maps each sequencer step to its control levels.
    function automatic sq_ctrl_t sq_decode(sq_state_t s);
        sq_ctrl_t c;
        c = '{pin_req: 1'b0, osc_on: 1'b0, sel_xtal: 1'b0, rc_on: 1'b1, done: 1'b0};
        case (s)
            SQ_PIN_GRANT: c.pin_req = 1'b1;
            SQ_OSC_START, SQ_SETTLE: begin
                c.pin_req = 1'b1;
                c.osc_on  = 1'b1;
            end
            SQ_HANDOVER: begin
                c.pin_req  = 1'b1;
                c.osc_on   = 1'b1;
                c.sel_xtal = 1'b1;
            end
            SQ_XTAL_RUN: begin
                c.pin_req  = 1'b1;
                c.osc_on   = 1'b1;
                c.sel_xtal = 1'b1;
                c.rc_on    = 1'b0;
                c.done     = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/slowclk_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer chain with selectable clock edge and reset level.
// Assumes: STAGES >= 2; reset is synchronous to clk and active low.
module slowclk_sync #(
    parameter int STAGES   = 2,
    parameter bit RST_VAL  = 1'b0,
    parameter bit NEG_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;
    localparam logic [STAGES-1:0] CHAIN_RST = {STAGES{RST_VAL}};

    logic [STAGES-1:0] chain;

    generate
        if (NEG_EDGE) begin : g_neg
            // Shifts the input through the chain on falling edges.
            always_ff @(negedge clk) begin
                if (!rst_n) chain <= CHAIN_RST;
                else        chain <= {chain[LAST-1:0], d};
            end
        end else begin : g_pos
            // Shifts the input through the chain on rising edges.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= CHAIN_RST;
                else        chain <= {chain[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain[LAST];

endmodule

// File: rtl/slowclk_settle_ctr.sv
`timescale 1ns/1ps
// Settling-time counter: counts while run is high, flags the wrap from all-ones to zero.
// Assumes: run is held high for the whole wait and dropped right after wrap.
module slowclk_settle_ctr #(
    parameter int CNT_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic wrap
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    logic [CNT_W-1:0] cnt;

    // Counts up during the wait and is cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign wrap = run && (cnt == CNT_LAST);

endmodule

// File: rtl/slowclk_seq_fsm.sv
`timescale 1ns/1ps
// One-way source switch sequencer, clocked by the RC slow clock.
// Steps: pins -> oscillator enable -> 2**CNT_W cycle wait -> mux select -> RC off.
// Assumes: wr_stb/wr_xtal_sel/bypass_mode are synchronous to clk; xtal_ack is synchronized.
module slowclk_seq_fsm
    import slowclk_seq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_xtal_sel,
    input  logic bypass_mode,
    input  logic xtal_ack,
    output logic pin_req,
    output logic amp_en,
    output logic byp_en,
    output logic sel_xtal,
    output logic rc_en,
    output logic done
);
    sq_state_t state, state_nx;
    sq_ctrl_t  ctrl;
    logic      byp_q;
    logic      start;
    logic      wait_run;
    logic      wait_wrap;

    assign start    = (state == SQ_RC_RUN) && wr_stb && wr_xtal_sel;
    assign wait_run = (state == SQ_SETTLE);

    slowclk_settle_ctr #(.CNT_W(CNT_W)) i_settle_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wait_run),
        .wrap  (wait_wrap)
    );

    // Chooses the next step; every step only moves forward.
    always_comb begin
        state_nx = state;
        case (state)
            SQ_RC_RUN:    if (start) state_nx = SQ_PIN_GRANT;
            SQ_PIN_GRANT: state_nx = SQ_OSC_START;
            SQ_OSC_START: state_nx = SQ_SETTLE;
            SQ_SETTLE:    if (wait_wrap) state_nx = SQ_HANDOVER;
            SQ_HANDOVER:  if (xtal_ack) state_nx = SQ_XTAL_RUN;
            SQ_XTAL_RUN:  state_nx = SQ_XTAL_RUN;
            default:      state_nx = SQ_RC_RUN;
        endcase
    end

    // Holds the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_RC_RUN;
        else        state <= state_nx;
    end

    // Captures the bypass choice together with the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)     byp_q <= 1'b0;
        else if (start) byp_q <= bypass_mode;
    end

    assign ctrl     = sq_decode(state);
    assign pin_req  = ctrl.pin_req;
    assign amp_en   = ctrl.osc_on & ~byp_q;
    assign byp_en   = ctrl.osc_on & byp_q;
    assign sel_xtal = ctrl.sel_xtal;
    assign rc_en    = ctrl.rc_on;
    assign done     = ctrl.done;

endmodule

// File: rtl/slowclk_gf_mux.sv
`timescale 1ns/1ps
// Glitch-free two-source clock multiplexer.
// Each path closes on its own falling edge and opens only after the other path is seen closed.
// Assumes: both clocks run while a change is in progress; the RC path is open out of reset.
module slowclk_gf_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic rst_n,
    input  logic rc_clk,
    input  logic xtal_clk,
    input  logic sel,
    output logic clk_out,
    output logic rc_path_on,
    output logic xt_path_on
);
    logic rc_req;
    logic xt_req;

    assign rc_req = ~sel & ~xt_path_on;
    assign xt_req = sel & ~rc_path_on;

    slowclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .NEG_EDGE(1'b1)) i_rc_gate (
        .clk   (rc_clk),
        .rst_n (rst_n),
        .d     (rc_req),
        .q     (rc_path_on)
    );

    slowclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .NEG_EDGE(1'b1)) i_xt_gate (
        .clk   (xtal_clk),
        .rst_n (rst_n),
        .d     (xt_req),
        .q     (xt_path_on)
    );

    assign clk_out = (rc_clk & rc_path_on) | (xtal_clk & xt_path_on);

endmodule

// File: rtl/slowclk_src_seq.sv
`timescale 1ns/1ps
// Top: slow clock source switch sequencer with glitch-free output multiplexer.
// Assumes: the write strobe is synchronous to rc_clk; rst_n is the power-on reset.
module slowclk_src_seq #(
    parameter int SETTLE_LOG2 = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic rst_n,
    input  logic rc_clk,
    input  logic xtal_clk,
    input  logic wr_stb,
    input  logic wr_xtal_sel,
    input  logic bypass_mode,
    output logic pin_handover,
    output logic rc_osc_en,
    output logic xtal_amp_en,
    output logic xtal_bypass,
    output logic clk_sel,
    output logic slow_clk,
    output logic switch_done
);
    logic rc_path_on;
    logic xt_path_on;
    logic xtal_ack;

    slowclk_seq_fsm #(.CNT_W(SETTLE_LOG2)) i_seq (
        .clk         (rc_clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_xtal_sel (wr_xtal_sel),
        .bypass_mode (bypass_mode),
        .xtal_ack    (xtal_ack),
        .pin_req     (pin_handover),
        .amp_en      (xtal_amp_en),
        .byp_en      (xtal_bypass),
        .sel_xtal    (clk_sel),
        .rc_en       (rc_osc_en),
        .done        (switch_done)
    );

    slowclk_gf_mux #(.SYNC_STAGES(SYNC_STAGES)) i_mux (
        .rst_n      (rst_n),
        .rc_clk     (rc_clk),
        .xtal_clk   (xtal_clk),
        .sel        (clk_sel),
        .clk_out    (slow_clk),
        .rc_path_on (rc_path_on),
        .xt_path_on (xt_path_on)
    );

    slowclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .NEG_EDGE(1'b0)) i_ack_sync (
        .clk   (rc_clk),
        .rst_n (rst_n),
        .d     (xt_path_on),
        .q     (xtal_ack)
    );

endmodule

// File: rtl/slowclk_src_seq_chk.sv
`timescale 1ns/1ps
// Property checker for slowclk_src_seq, attached through bind.
module slowclk_src_seq_chk (
    input logic rst_n,
    input logic rc_clk,
    input logic wr_stb,
    input logic wr_xtal_sel,
    input logic pin_handover,
    input logic rc_osc_en,
    input logic xtal_amp_en,
    input logic xtal_bypass,
    input logic clk_sel,
    input logic switch_done,
    input logic rc_path_on,
    input logic xt_path_on
);
    AST_IDLE_QUIET: assert property (@(posedge rc_clk) disable iff (!rst_n)
        !pin_handover |-> (rc_osc_en && !xtal_amp_en && !xtal_bypass && !clk_sel && !switch_done)) else $error("idle outputs"); // R1
    AST_SEL0_NO_START: assert property (@(posedge rc_clk) disable iff (!rst_n)
        (!pin_handover && wr_stb && !wr_xtal_sel) |=> !pin_handover) else $error("select-0 write started"); // R2
    AST_START: assert property (@(posedge rc_clk) disable iff (!rst_n)
        (!pin_handover && wr_stb && wr_xtal_sel) |=> pin_handover) else $error("command not taken"); // R2
    AST_PINS_FIRST: assert property (@(posedge rc_clk) disable iff (!rst_n)
        (xtal_amp_en || xtal_bypass) |-> pin_handover) else $error("oscillator before pins"); // R3
    AST_OSC_FOLLOWS: assert property (@(posedge rc_clk) disable iff (!rst_n)
        $rose(pin_handover) |=> (xtal_amp_en || xtal_bypass)) else $error("oscillator late"); // R3
    AST_SEL_AFTER_OSC: assert property (@(posedge rc_clk) disable iff (!rst_n)
        clk_sel |-> (xtal_amp_en || xtal_bypass)) else $error("select without oscillator"); // R4
    AST_RC_OFF_LAST: assert property (@(posedge rc_clk) disable iff (!rst_n)
        !rc_osc_en |-> (switch_done && clk_sel)) else $error("RC off early"); // R6
    AST_DONE_STICKY: assert property (@(posedge rc_clk) disable iff (!rst_n)
        switch_done |=> (switch_done && !rc_osc_en && clk_sel)) else $error("done lost"); // R7
    AST_SEL_STICKY: assert property (@(posedge rc_clk) disable iff (!rst_n)
        clk_sel |=> clk_sel) else $error("select went back"); // R7
    AST_OSC_EXCL: assert property (@(posedge rc_clk) disable iff (!rst_n)
        !(xtal_amp_en && xtal_bypass)) else $error("amplifier and bypass together"); // R8

    // Checks that the two source paths are never open at once.
    always_comb begin
        if (rst_n) begin
            AST_ONE_SOURCE: assert (!(rc_path_on && xt_path_on)) else $error("both paths open"); // R5
        end
    end
endmodule

bind slowclk_src_seq slowclk_src_seq_chk i_chk (
    .rst_n        (rst_n),
    .rc_clk       (rc_clk),
    .wr_stb       (wr_stb),
    .wr_xtal_sel  (wr_xtal_sel),
    .pin_handover (pin_handover),
    .rc_osc_en    (rc_osc_en),
    .xtal_amp_en  (xtal_amp_en),
    .xtal_bypass  (xtal_bypass),
    .clk_sel      (clk_sel),
    .switch_done  (switch_done),
    .rc_path_on   (rc_path_on),
    .xt_path_on   (xt_path_on)
);

// File: tb/test_slowclk_src_seq.sv
`timescale 1ns/1ps
module test_slowclk_src_seq;
    logic rst_n = 1'b0;
    logic rc_clk = 1'b0;
    logic xtal_clk = 1'b0;
    logic wr_stb = 1'b0;
    logic wr_xtal_sel = 1'b0;
    logic bypass_mode = 1'b0;
    logic pin_handover, rc_osc_en, xtal_amp_en, xtal_bypass, clk_sel, slow_clk, switch_done;

    int  n_chk = 0;
    int  n_fail = 0;
    int  runts = 0;
    bit  mon_en = 1'b0;
    real t_last = 0.0;

    localparam int SETTLE = 32768;

    always #2 rc_clk = ~rc_clk;
    always #3 xtal_clk = ~xtal_clk;

    slowclk_src_seq i_slowclk_src_seq (
        .rst_n(rst_n), .rc_clk(rc_clk), .xtal_clk(xtal_clk), .wr_stb(wr_stb),
        .wr_xtal_sel(wr_xtal_sel), .bypass_mode(bypass_mode), .pin_handover(pin_handover),
        .rc_osc_en(rc_osc_en), .xtal_amp_en(xtal_amp_en), .xtal_bypass(xtal_bypass),
        .clk_sel(clk_sel), .slow_clk(slow_clk), .switch_done(switch_done)
    );

    // Runt monitor: any output phase shorter than 1.5 ns counts as a glitch.
    always @(slow_clk) begin
        if (mon_en) begin
            if ($realtime - t_last < 1.5) runts++;
            t_last = $realtime;
        end
    end

    // Expected {pin_handover, xtal_amp_en, xtal_bypass, clk_sel, rc_osc_en, switch_done}.
    // Phase: 0 idle, 1 pins, 2 oscillator on, 3 settling, 4 handover, 5 done.
    function automatic logic [5:0] exp_vec(int ph, bit byp);
        case (ph)
            0:       return 6'b000010;
            1:       return 6'b100010;
            2, 3:    return {1'b1, ~byp, byp, 1'b0, 1'b1, 1'b0};
            4:       return {1'b1, ~byp, byp, 1'b1, 1'b1, 1'b0};
            default: return {1'b1, ~byp, byp, 1'b1, 1'b0, 1'b1};
        endcase
    endfunction

    function automatic logic [5:0] act_vec();
        return {pin_handover, xtal_amp_en, xtal_bypass, clk_sel, rc_osc_en, switch_done};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        @(negedge rc_clk);
        rst_n = 1'b0;
        wr_stb = 1'b0;
        repeat (4) @(posedge rc_clk);
        #1 chk(act_vec(), exp_vec(0, 1'b0), "R1", "outputs in reset");
        @(negedge rc_clk);
        rst_n = 1'b1;
        repeat (3) @(posedge rc_clk);
        #1;
        t_last = $realtime - 10.0;
        mon_en = 1'b1;
    endtask

    task automatic follow_chk(input bit use_xtal, input string req);
        int bad = 0;
        for (int i = 0; i < 8; i++) begin
            if (use_xtal) begin
                @(posedge xtal_clk); #1 if (slow_clk !== 1'b1) bad++;
                @(negedge xtal_clk); #1 if (slow_clk !== 1'b0) bad++;
            end else begin
                @(posedge rc_clk); #1 if (slow_clk !== 1'b1) bad++;
                @(negedge rc_clk); #1 if (slow_clk !== 1'b0) bad++;
            end
        end
        chk(bad, 0, req, use_xtal ? "slow_clk follows crystal" : "slow_clk follows RC");
    endtask

    // Full switch sequence; optional random writes during the settling wait.
    task automatic run_full(input bit byp, input bit noise);
        int bad = 0;
        int waited = 0;
        @(negedge rc_clk);
        wr_stb = 1'b1; wr_xtal_sel = 1'b1; bypass_mode = byp;
        @(posedge rc_clk);
        #1 chk(act_vec(), exp_vec(1, byp), "R2", "pins after command");
        wr_stb = 1'b0;
        @(posedge rc_clk);
        #1 chk(act_vec(), exp_vec(2, byp), "R3", "oscillator enable one edge after pins");
        for (int i = 0; i < SETTLE; i++) begin
            if (noise) begin
                wr_stb = 1'($urandom_range(0, 1));
                wr_xtal_sel = 1'($urandom_range(0, 1));
                bypass_mode = 1'($urandom_range(0, 1));
            end
            @(posedge rc_clk);
            #1 if (act_vec() !== exp_vec(3, byp)) bad++;
        end
        wr_stb = 1'b0;
        chk(bad, 0, noise ? "R9" : "R4", "outputs steady for whole wait");
        chk(clk_sel, 1'b0, "R4", "select still low at edge 32768");
        @(posedge rc_clk);
        #1 chk(act_vec(), exp_vec(4, byp), "R4", "select high at edge 32769");
        bad = 0;
        while (!switch_done && waited < 40) begin
            if (act_vec() !== exp_vec(4, byp)) bad++;
            @(posedge rc_clk);
            #1 waited++;
        end
        chk(bad, 0, "R6", "RC kept on until completion");
        chk(waited <= 16, 1'b1, "R6", "completion within 16 cycles");
        chk(act_vec(), exp_vec(5, byp), "R6", "done and RC off together");
        follow_chk(1'b1, "R5");
        for (int i = 0; i < 10; i++) begin
            wr_stb = 1'b1;
            wr_xtal_sel = 1'($urandom_range(0, 1));
            bypass_mode = 1'($urandom_range(0, 1));
            @(posedge rc_clk);
            #1 chk(act_vec(), exp_vec(5, byp), "R7", "state holds after completion");
        end
        wr_stb = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        follow_chk(1'b0, "R1");
        // Random writes with select 0 while idle.
        for (int i = 0; i < 20; i++) begin
            wr_stb = 1'($urandom_range(0, 1));
            wr_xtal_sel = 1'b0;
            bypass_mode = 1'($urandom_range(0, 1));
            @(posedge rc_clk);
            #1 chk(act_vec(), exp_vec(0, 1'b0), "R2", "select-0 write ignored");
        end
        wr_stb = 1'b0;
        // Reset in the middle of the wait restores RC operation.
        @(negedge rc_clk);
        wr_stb = 1'b1; wr_xtal_sel = 1'b1; bypass_mode = 1'b0;
        @(posedge rc_clk);
        #1 wr_stb = 1'b0;
        repeat (100) @(posedge rc_clk);
        #1 chk(act_vec(), exp_vec(3, 1'b0), "R3", "mid-wait state");
        do_reset();
        chk(act_vec(), exp_vec(0, 1'b0), "R7", "reset restores RC operation");
        follow_chk(1'b0, "R7");
        run_full(1'b1, 1'b0);   // R8 bypass path
        do_reset();
        run_full(1'b0, 1'b1);   // R9 noise during wait, R8 latched choice
        chk(runts, 0, "R5", "no runt phase on slow_clk");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge rc_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule